// File: doc/BRIEF.md
# Dual-Pointer Audio DMA Channel

This block moves audio samples between system memory and a byte-serial codec in both directions at once. Each direction owns a current block pointer and a next block pointer. The engine walks through one block of 32-bit words at a time. When it reaches the end of a block, it takes the next pointer as the new current pointer, marks the next pointer as consumed, and raises a per-direction load flag. Software answers the interrupt by writing a fresh next pointer while the hardware works on the block it has just adopted.

Every 32-bit memory word carries a single 8-bit sample in bits 23:16. On transmit, words are fetched ahead of time into a one-word holding register, and a codec sample strobe moves the held byte to the codec. On receive, each strobe captures the codec byte and writes it to memory as one word. One memory port serves both directions, and a pending receive write is granted before a transmit fetch. A control bit holds the codec in reset. The reset is always kept for a minimum number of cycles.

The register port is word-indexed: 0 control, 1 interrupt status, 2 transmit current, 3 transmit next, 4 receive current, 5 receive next.

Top module: `audio_dma_engine`

## Requirements
- R1: After reset, both current and both next pointers read 0xFFFFFFFF (the invalid marker), control and interrupt status read 0, `irq` is low, `codec_rst_n` is low and `mem_req` is low.
- R2: With control bit 0 (transmit enable) set and a valid transmit current pointer, words of the block are read in ascending order. On each `smp_strobe`, bits 23:16 of the oldest fetched word appear on `tx_sample`.
- R3: With control bit 1 (receive enable) set and a valid receive current pointer, each `smp_strobe` writes the word {8'h00, rx_sample, 16'h0000} to the next ascending word of the block.
- R4: Word addresses are the pointer with its low log2(4*BLK_WORDS) bits replaced by the word index times 4. The low bits written to a pointer are ignored for addressing, but they still read back as written.
- R5: When the last word of a block completes and the next pointer is valid, the next pointer becomes the current pointer and the next pointer becomes 0xFFFFFFFF. The load flag is also set: status bit 0 for transmit, bit 1 for receive.
- R6: When the last word of a block completes and the next pointer is 0xFFFFFFFF, the current pointer becomes 0xFFFFFFFF and that direction's enable bit clears. The error flag is set (status bit 2 transmit, bit 3 receive), and that direction issues no further memory requests.
- R7: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly while any status bit is set.
- R8: The enable bits act independently. A cleared direction starts no memory access and captures no samples, while the other direction keeps running.
- R9: While control bit 2 is clear, `codec_rst_n` is low. After each fall of `codec_rst_n`, it stays low for exactly RST_CYC cycles if bit 2 is set again at once.
- R10: A strobe that finds the transmit holding register empty drives `tx_sample` to 0.
- R11: Once `mem_req` is raised, it stays high with a stable `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Any status flag pending |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write (receive), 0 for read (transmit) |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| smp_strobe | input | 1 | Codec sample-rate strobe |
| rx_sample | input | 8 | Sample from codec |
| tx_sample | output | 8 | Sample to codec |
| codec_rst_n | output | 1 | Active-low codec reset |

## Verification
The hardest case to reach is the end of a block whose next pointer has already been consumed. Reaching it needs a full block to finish, a hand-off, and a second full block to run without a software refill. The transmit test therefore uses a four-word block and runs two blocks back to back, leaving the next pointer unwritten after the first load interrupt. It keeps strobing past the stop, so the last prefetched word drains and is followed by an underrun sample of 0. The memory model answers after a two-cycle wait, so a request is held open across several edges, and its address is compared on every cycle of the wait.

// File: rtl/audma_pkg.sv
// Shared constants and types of the audio DMA engine.
package audma_pkg;
    localparam int PTR_W = 32;

    // register word indices
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_TXCUR = 3'd2;
    localparam logic [2:0] RA_TXNXT = 3'd3;
    localparam logic [2:0] RA_RXCUR = 3'd4;
    localparam logic [2:0] RA_RXNXT = 3'd5;

    // control bits
    localparam int CB_TX    = 0;
    localparam int CB_RX    = 1;
    localparam int CB_CODEC = 2;

    // status bits
    localparam int SB_TXLD  = 0;
    localparam int SB_RXLD  = 1;
    localparam int SB_TXERR = 2;
    localparam int SB_RXERR = 3;

    // end-of-block events from a channel
    typedef struct packed {
        logic load;
        logic err;
    } chan_evt_t;
endpackage

// File: rtl/audma_codec_rst.sv
// Codec reset stretcher.
// Holds codec_rst_n low while codec_en is clear. After every fall it keeps
// the reset low for at least RST_CYC cycles. Assumes RST_CYC >= 2.
module audma_codec_rst #(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic codec_en,
    output logic codec_rst_n
);
    localparam int CW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(RST_CYC - 1);

    logic          rel_q;
    logic [CW-1:0] cnt_q;

    // count reset cycles; release once the minimum has passed and enable is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q <= 1'b0;
            cnt_q <= '0;
        end else if (rel_q) begin
            if (!codec_en) begin
                rel_q <= 1'b0;
                cnt_q <= '0;
            end
        end else begin
            if (cnt_q < CNT_TOP) cnt_q <= cnt_q + 1'b1;
            if (codec_en && cnt_q >= CNT_TOP) rel_q <= 1'b1;
        end
    end

    assign codec_rst_n = rel_q;

    AST_CODEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_en |=> !codec_rst_n);                                   // R9
    AST_CODEC_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        codec_rst_n |-> cnt_q >= CNT_TOP);                             // R9
endmodule

// File: rtl/audma_chan.sv
// One DMA direction: current/next pointer pair, word index and sample path.
// IS_RX selects the receive variant, which writes captured samples. The
// transmit variant prefetches words into a one-word holding register.
// Assumes the memory side acknowledges each request exactly once.
module audma_chan
    import audma_pkg::*;
#(
    parameter int BLK_WORDS = 1024,
    parameter bit IS_RX     = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cur_we,
    input  logic             nxt_we,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] cur_ptr,
    output logic [PTR_W-1:0] nxt_ptr,
    input  logic             smp_strobe,
    input  logic [7:0]       rx_sample,
    output logic [7:0]       tx_sample,
    output logic             mem_req,
    output logic [PTR_W-1:0] mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [7:0]       mem_rbyte,
    output chan_evt_t        evt
);
    localparam int IDX_W = $clog2(BLK_WORDS);
    localparam int OFF_W = IDX_W + 2;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_WORDS - 1);

    logic [PTR_W-1:0] cur_q, nxt_q, addr_q;
    logic [IDX_W-1:0] idx_q;
    logic             req_q;
    logic [7:0]       data_q;
    logic             data_v;
    logic             cur_ok, nxt_ok, blk_last, done, issue;
    logic [PTR_W-1:0] word_addr;

    assign cur_ok    = (cur_q != '1);
    assign nxt_ok    = (nxt_q != '1);
    assign blk_last  = (idx_q == IDX_LAST);
    assign done      = req_q && mem_ack;
    assign word_addr = {cur_q[PTR_W-1:OFF_W], idx_q, 2'b00};

    generate
        if (IS_RX) begin : g_rx
            logic [31:0] wd_q;
            assign issue = data_v && !req_q && cur_ok;

            // capture a codec sample on each strobe while running
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                    data_v <= 1'b0;
                end else if (smp_strobe && en && cur_ok) begin
                    data_q <= rx_sample;
                    data_v <= 1'b1;
                end else if (issue || !cur_ok) begin
                    data_v <= 1'b0;
                end
            end

            // latch the write word when the request starts
            always_ff @(posedge clk) begin
                if (!rst_n)     wd_q <= '0;
                else if (issue) wd_q <= {8'h00, data_q, 16'h0000};
            end

            assign mem_wdata = wd_q;
            assign tx_sample = 8'h00;
        end else begin : g_tx
            logic [7:0] out_q;
            assign issue = en && cur_ok && !data_v && !req_q;

            // fill the holding register from memory, empty it on strobe
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                    data_v <= 1'b0;
                end else if (done) begin
                    data_q <= mem_rbyte;
                    data_v <= 1'b1;
                end else if (smp_strobe) begin
                    data_v <= 1'b0;
                end
            end

            // present the held sample, or silence on underrun
            always_ff @(posedge clk) begin
                if (!rst_n)          out_q <= '0;
                else if (smp_strobe) out_q <= data_v ? data_q : 8'h00;
            end

            assign mem_wdata = '0;
            assign tx_sample = out_q;
        end
    endgenerate

    // request register: raised on issue, held until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else if (done) begin
            req_q  <= 1'b0;
        end else if (issue) begin
            req_q  <= 1'b1;
            addr_q <= word_addr;
        end
    end

    // pointer chaining and word index; software writes take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '1;
            nxt_q <= '1;
            idx_q <= '0;
        end else begin
            if (done) begin
                if (blk_last) begin
                    idx_q <= '0;
                    if (nxt_ok) begin
                        cur_q <= nxt_q;
                        nxt_q <= '1;
                    end else begin
                        cur_q <= '1;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (nxt_we) nxt_q <= wdata;
            if (cur_we) begin
                cur_q <= wdata;
                idx_q <= '0;
            end
        end
    end

    assign evt.load = done && blk_last && nxt_ok;
    assign evt.err  = done && blk_last && !nxt_ok;
    assign cur_ptr  = cur_q;
    assign nxt_ptr  = nxt_q;
    assign mem_req  = req_q;
    assign mem_addr = addr_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));         // R11
    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        evt.load && !cur_we |=> cur_ptr == $past(nxt_ptr));            // R5
    AST_NXT_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        evt.load && !nxt_we |=> nxt_ptr == '1);                        // R5
    AST_ERR_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        evt.err && !cur_we |=> cur_ptr == '1);                         // R6
endmodule

// File: rtl/audio_dma_engine.sv
// Dual-pointer audio DMA engine top.
// Holds the control and status registers, arbitrates one memory port
// between the two directions (receive first) and drives the codec reset.
// Assumes BLK_WORDS is a power of two and at least 2.
module audio_dma_engine
    import audma_pkg::*;
#(
    parameter int BLK_WORDS = 1024,
    parameter int RST_CYC   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             smp_strobe,
    input  logic [7:0]       rx_sample,
    output logic [7:0]       tx_sample,
    output logic             codec_rst_n
);
    logic [2:0]       ctrl_q;
    logic [3:0]       stat_q;
    logic [3:0]       stat_clr;
    logic             busy_q, own_rx_q, sel_rx;
    chan_evt_t        tx_evt, rx_evt;
    logic [PTR_W-1:0] tx_cur, tx_nxt, rx_cur, rx_nxt;
    logic             tx_req, rx_req;
    logic [PTR_W-1:0] tx_addr, rx_addr;
    logic [31:0]      tx_wd, rx_wd;
    logic [7:0]       rx_unused_out;

    audma_chan #(.BLK_WORDS(BLK_WORDS), .IS_RX(1'b0)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_TX]),
        .cur_we(reg_wr && reg_addr == RA_TXCUR),
        .nxt_we(reg_wr && reg_addr == RA_TXNXT),
        .wdata(reg_wdata), .cur_ptr(tx_cur), .nxt_ptr(tx_nxt),
        .smp_strobe(smp_strobe), .rx_sample(8'h00), .tx_sample(tx_sample),
        .mem_req(tx_req), .mem_addr(tx_addr), .mem_wdata(tx_wd),
        .mem_ack(mem_ack && !sel_rx), .mem_rbyte(mem_rdata[23:16]),
        .evt(tx_evt));

    audma_chan #(.BLK_WORDS(BLK_WORDS), .IS_RX(1'b1)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_RX]),
        .cur_we(reg_wr && reg_addr == RA_RXCUR),
        .nxt_we(reg_wr && reg_addr == RA_RXNXT),
        .wdata(reg_wdata), .cur_ptr(rx_cur), .nxt_ptr(rx_nxt),
        .smp_strobe(smp_strobe), .rx_sample(rx_sample), .tx_sample(rx_unused_out),
        .mem_req(rx_req), .mem_addr(rx_addr), .mem_wdata(rx_wd),
        .mem_ack(mem_ack && sel_rx), .mem_rbyte(mem_rdata[23:16]),
        .evt(rx_evt));

    audma_codec_rst #(.RST_CYC(RST_CYC)) u_crst (
        .clk(clk), .rst_n(rst_n), .codec_en(ctrl_q[CB_CODEC]),
        .codec_rst_n(codec_rst_n));

    // control word: software writes, a stopped channel clears its enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) ctrl_q <= reg_wdata[2:0];
            if (tx_evt.err) ctrl_q[CB_TX] <= 1'b0;
            if (rx_evt.err) ctrl_q[CB_RX] <= 1'b0;
        end
    end

    assign stat_clr = (reg_wr && reg_addr == RA_STAT) ? reg_wdata[3:0] : 4'h0;

    // status flags: write-one-to-clear, new events win
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) |
                              {rx_evt.err, tx_evt.err, rx_evt.load, tx_evt.load};
    end

    // memory port ownership: receive first, held until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            own_rx_q <= 1'b0;
        end else if (mem_ack) begin
            busy_q   <= 1'b0;
        end else if (!busy_q && mem_req) begin
            busy_q   <= 1'b1;
            own_rx_q <= rx_req;
        end
    end

    assign sel_rx    = busy_q ? own_rx_q : rx_req;
    assign mem_req   = tx_req || rx_req;
    assign mem_we    = sel_rx;
    assign mem_addr  = sel_rx ? rx_addr : tx_addr;
    assign mem_wdata = sel_rx ? rx_wd : tx_wd;
    assign irq       = |stat_q;

    // register read mux
    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {29'd0, ctrl_q};
            RA_STAT:  reg_rdata = {28'd0, stat_q};
            RA_TXCUR: reg_rdata = tx_cur;
            RA_TXNXT: reg_rdata = tx_nxt;
            RA_RXCUR: reg_rdata = rx_cur;
            RA_RXNXT: reg_rdata = rx_nxt;
            default:  reg_rdata = 32'd0;
        endcase
    end

    AST_ERR_STOPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt.err |=> !ctrl_q[CB_TX]);                                // R6
    AST_ERR_STOPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt.err |=> !ctrl_q[CB_RX]);                                // R6
    AST_LOAD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt.load || rx_evt.load) |=> irq);                         // R5
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !mem_ack |=> $stable(sel_rx));                       // R11
endmodule

// File: tb/audio_dma_engine_tb.sv
module audio_dma_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BLK       = 4;
    localparam int RST_CYC   = 10;
    localparam int LAT       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        smp_strobe = 1'b0;
    logic [7:0]  rx_sample = '0;
    logic [7:0]  tx_sample;
    logic        codec_rst_n;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_dma_engine #(.BLK_WORDS(BLK), .RST_CYC(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .smp_strobe(smp_strobe), .rx_sample(rx_sample), .tx_sample(tx_sample),
        .codec_rst_n(codec_rst_n));

    // memory model: answers after LAT waiting cycles, logs every access
    logic [31:0] wmem [0:1023];
    logic [31:0] rd_log [0:31];
    int rd_n = 0, wr_n = 0, wait_c = 0, unstable = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [7:0] smp_of(input logic [31:0] a);
        return a[9:2] ^ 8'h3C;
    endfunction

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_c == 0) pend_addr = mem_addr;
            else if (mem_addr != pend_addr) unstable++;
            if (wait_c < LAT) begin
                wait_c++;
            end else begin
                wait_c = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    wmem[mem_addr[11:2]] = mem_wdata;
                    wr_n++;
                end else begin
                    mem_rdata = {8'h5A, smp_of(mem_addr), 16'hC396};
                    if (rd_n < 32) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end
        end
    end

    // length of the last low phase of the codec reset
    int low_run = 0, last_low = 0;
    always @(negedge clk) begin
        if (!codec_rst_n) low_run++;
        else if (low_run != 0) begin
            last_low = low_run;
            low_run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic strobe(input logic [7:0] s);
        @(negedge clk);
        rx_sample = s; smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check(v == ((a < 2) ? 32'h0 : 32'hFFFF_FFFF), "R1 register", v,
                  (a < 2) ? 32'h0 : 32'hFFFF_FFFF);
        end
        check(!irq && !codec_rst_n && !mem_req, "R1 pins",
              {irq, codec_rst_n, mem_req}, 0);
    endtask

    task automatic t_codec();
        repeat (2 * RST_CYC) @(negedge clk);
        check(!codec_rst_n, "R9 held while clear", codec_rst_n, 0);
        wr(0, 32'h4);
        repeat (RST_CYC + 4) @(negedge clk);
        check(codec_rst_n, "R9 released", codec_rst_n, 1);
        wr(0, 32'h0);
        wr(0, 32'h4);
        repeat (RST_CYC + 4) @(negedge clk);
        check(last_low == RST_CYC, "R9 minimum width", last_low, RST_CYC);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        logic [31:0] exp_a [0:7];
        for (int i = 0; i < 4; i++) exp_a[i] = 32'h100 + 32'(4 * i);
        for (int i = 0; i < 4; i++) exp_a[4 + i] = 32'h200 + 32'(4 * i);
        wr(2, 32'h10F);
        wr(3, 32'h200);
        wr(0, 32'h5);
        repeat (10) @(negedge clk);
        check(tx_sample == 8'h00, "R2 before first strobe", tx_sample, 0);
        for (int i = 0; i < 3; i++) begin
            strobe(8'h00);
            check(tx_sample == smp_of(exp_a[i]), "R2 sample", tx_sample, smp_of(exp_a[i]));
        end
        rd(1, v);
        check(v == 32'h1 && irq, "R5 tx load flag", v, 32'h1);
        rd(2, v);
        check(v == 32'h200, "R5 current takes next", v, 32'h200);
        rd(3, v);
        check(v == 32'hFFFF_FFFF, "R5 next consumed", v, 32'hFFFF_FFFF);
        wr(1, 32'h0);
        rd(1, v);
        check(v == 32'h1 && irq, "R7 write zero keeps flag", v, 32'h1);
        wr(1, 32'h1);
        rd(1, v);
        check(v == 32'h0 && !irq, "R7 write one clears", {irq, v[30:0]}, 0);
        for (int i = 3; i < 8; i++) begin
            strobe(8'h00);
            check(tx_sample == smp_of(exp_a[i]), "R2 sample", tx_sample, smp_of(exp_a[i]));
        end
        strobe(8'h00);
        check(tx_sample == 8'h00, "R10 underrun gives zero", tx_sample, 0);
        check(rd_n == 8, "R6 no fetch after stop", rd_n, 8);
        for (int i = 0; i < 8; i++)
            check(rd_log[i] == exp_a[i], "R4 fetch address", rd_log[i], exp_a[i]);
        rd(1, v);
        check(v == 32'h4 && irq, "R6 tx error flag", v, 32'h4);
        rd(0, v);
        check(v == 32'h4, "R6 enable cleared", v, 32'h4);
        rd(2, v);
        check(v == 32'hFFFF_FFFF, "R6 current invalid", v, 32'hFFFF_FFFF);
        wr(1, 32'hF);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        logic [7:0]  s;
        int rd_before, wr_before;
        rd_before = rd_n;
        wr(4, 32'h403);
        wr(5, 32'h500);
        wr(0, 32'h6);
        for (int i = 0; i < 5; i++) strobe(8'h11 * 8'(i + 1));
        for (int i = 0; i < 4; i++) begin
            s = 8'h11 * 8'(i + 1);
            v = wmem[10'h100 + 10'(i)];
            check(v == {8'h00, s, 16'h0}, "R3 written word", v, {8'h00, s, 16'h0});
        end
        v = wmem[10'h140];
        check(v == 32'h0055_0000, "R3 word after hand-off", v, 32'h0055_0000);
        rd(1, v);
        check(v == 32'h2, "R5 rx load flag", v, 32'h2);
        rd(4, v);
        check(v == 32'h500, "R5 rx current takes next", v, 32'h500);
        check(rd_n == rd_before, "R8 disabled tx fetches nothing", rd_n, rd_before);
        wr(0, 32'h4);
        wr_before = wr_n;
        strobe(8'h99);
        strobe(8'h98);
        check(wr_n == wr_before, "R8 disabled rx writes nothing", wr_n, wr_before);
        check(unstable == 0, "R11 request held stable", unstable, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_codec();
        t_tx();
        t_rx();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule